// File: doc/BRIEF.md
# Linear Sweep Ramp Generator

This block generates a control value that climbs or falls in equal increments between two programmed bounds. A typical use is as the tuning word of a phase-accumulator synthesizer, which then emits a linear chirp such as a radar sweep. The same output can instead drive a phase offset or an amplitude scale, so one mechanism covers all three kinds of ramp.

Software programs a lower bound, an upper bound, an increment of `DELTA_W` bits and a step-rate factor K through a small write port. A one-cycle start pulse launches the sweep. The sweep begins at the lower bound for a rising sweep, or at the upper bound for a falling one. After that the increment is added or subtracted once every K clocks in a `ACC_W`-bit accumulator. The sweep halts at the last value inside the bounds and flags its completion for one clock.

A direction input can be changed at any moment. The next step uses the new direction and continues from the value already reached.

Top module: `lin_sweep_acc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ramp_value` is 0 and both `ramp_active` and `ramp_done` are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_addr`. Address 0 holds the lower bound and address 1 holds the upper bound, both `ACC_W` bits. Address 2 holds the increment, taken from the low `DELTA_W` bits. Address 3 holds the rate factor K, taken from the low `RATE_W` bits.
- R3: A clock edge that samples `sweep_go` high loads `ramp_value` and raises `ramp_active` at that same edge. The loaded value is the lower bound when `sweep_down` is 0 and the upper bound when `sweep_down` is 1.
- R4: While active, `ramp_value` moves by exactly the increment every K clocks. The first step comes K clocks after the load edge. The value rises when `sweep_down` is 0 and falls when it is 1.
- R5: A rate factor of K = 0 gives the same timing as K = 1, which is one step on every clock.
- R6: On a rising sweep, a step that lands exactly on the upper bound is taken. A step that would go past the upper bound is not taken, and the value holds.
- R7: On a falling sweep, a step that lands exactly on the lower bound is taken. A step that would go below the lower bound is not taken, and the value holds.
- R8: If `sweep_down` changes while a sweep runs, the next step moves from the current value in the new direction, with no reload and no jump.
- R9: At the step where the sweep stops, `ramp_done` is high for exactly one clock and `ramp_active` falls at the same edge. After that, `ramp_value` does not change until the next start.
- R10: The bound comparisons are free of wraparound. A rising step whose sum exceeds 2^ACC_W - 1 counts as passing the upper bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | ACC_W | Configuration write data |
| sweep_go | input | 1 | Start pulse; loads the start value |
| sweep_down | input | 1 | 0 = rising sweep, 1 = falling sweep |
| ramp_value | output | ACC_W | Current ramp value |
| ramp_active | output | 1 | High while a sweep is running |
| ramp_done | output | 1 | One-clock pulse when a sweep stops |

## Verification
The assertions check the following on every cycle:
- the done pulse is a single clock long and coincides with the sweep going idle;
- an idle ramp never moves without a start;
- every change during a sweep equals the increment in one direction or the other;
- a start always makes the ramp active.

Other properties can only be shown by the bench scenarios. These are:
- the exact cycle spacing of K clocks, including K = 0;
- which start value is chosen;
- exact landing on a bound versus stopping short of it;
- continuation after a direction flip;
- a rising step whose sum wraps past the top of the accumulator range.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        REG_LOW  = 2'd0,
        REG_HIGH = 2'd1,
        REG_STEP = 2'd2,
        REG_RATE = 2'd3
    } sweep_reg_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        logic active;
        logic done;
    } run_flags_t;

    function automatic sweep_dir_e dir_from_pin(input logic down);
        return down ? DIR_DOWN : DIR_UP;
    endfunction

endpackage

// File: rtl/sweep_cfg_regs.sv
module sweep_cfg_regs
    import sweep_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int DELTA_W = 16,
    parameter int RATE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [ACC_W-1:0]   wdata,
    output logic [ACC_W-1:0]   bound_lo,
    output logic [ACC_W-1:0]   bound_hi,
    output logic [DELTA_W-1:0] step_amt,
    output logic [RATE_W-1:0]  rate_k
);
    sweep_reg_e sel;
    assign sel = sweep_reg_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_lo <= '0;
            bound_hi <= '0;
            step_amt <= '0;
            rate_k   <= '0;
        end else if (we) begin
            case (sel)
                REG_LOW:  bound_lo <= wdata;
                REG_HIGH: bound_hi <= wdata;
                REG_STEP: step_amt <= wdata[DELTA_W-1:0];
                REG_RATE: rate_k   <= wdata[RATE_W-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/sweep_rate_div.sv
module sweep_rate_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_k,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload;

    assign reload = (rate_k == '0) ? '0 : rate_k - 1'b1;
    assign tick   = run && !load && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load || tick) begin
            cnt_q <= reload;
        end else if (run) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sweep_step_unit.sv
module sweep_step_unit
    import sweep_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int DELTA_W = 16
) (
    input  logic [ACC_W-1:0]   cur,
    input  logic [DELTA_W-1:0] step_amt,
    input  logic [ACC_W-1:0]   bound_lo,
    input  logic [ACC_W-1:0]   bound_hi,
    input  sweep_dir_e         dir,
    output logic [ACC_W-1:0]   next_val,
    output logic               hit
);
    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] cur_x, step_x, up_sum, lo_floor;

    always_comb begin
        cur_x    = {1'b0, cur};
        step_x   = {{(EXT_W-DELTA_W){1'b0}}, step_amt};
        up_sum   = cur_x + step_x;
        lo_floor = {1'b0, bound_lo} + step_x;
        if (dir == DIR_UP) begin
            hit      = up_sum > {1'b0, bound_hi};
            next_val = up_sum[ACC_W-1:0];
        end else begin
            hit      = cur_x < lo_floor;
            next_val = cur - step_x[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/lin_sweep_acc.sv
module lin_sweep_acc
    import sweep_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int DELTA_W = 16,
    parameter int RATE_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [ACC_W-1:0] cfg_wdata,
    input  logic             sweep_go,
    input  logic             sweep_down,
    output logic [ACC_W-1:0] ramp_value,
    output logic             ramp_active,
    output logic             ramp_done
);
    logic [ACC_W-1:0]   bound_lo, bound_hi, next_val, delta_val;
    logic [DELTA_W-1:0] step_amt;
    logic [RATE_W-1:0]  rate_k;
    logic               tick, hit;
    sweep_dir_e         dir;
    logic [ACC_W-1:0]   value_q;
    run_flags_t         flags_q;

    assign dir       = dir_from_pin(sweep_down);
    assign delta_val = {{(ACC_W-DELTA_W){1'b0}}, step_amt};

    sweep_cfg_regs #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .RATE_W(RATE_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .bound_lo(bound_lo), .bound_hi(bound_hi), .step_amt(step_amt), .rate_k(rate_k)
    );

    sweep_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst(rst), .load(sweep_go), .run(flags_q.active),
        .rate_k(rate_k), .tick(tick)
    );

    sweep_step_unit #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_step (
        .cur(value_q), .step_amt(step_amt), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .dir(dir), .next_val(next_val), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            flags_q <= '0;
        end else if (sweep_go) begin
            value_q        <= (dir == DIR_DOWN) ? bound_hi : bound_lo;
            flags_q.active <= 1'b1;
            flags_q.done   <= 1'b0;
        end else if (tick) begin
            if (hit) begin
                flags_q.active <= 1'b0;
                flags_q.done   <= 1'b1;
            end else begin
                value_q      <= next_val;
                flags_q.done <= 1'b0;
            end
        end else begin
            flags_q.done <= 1'b0;
        end
    end

    assign ramp_value  = value_q;
    assign ramp_active = flags_q.active;
    assign ramp_done   = flags_q.done;
endmodule

// File: rtl/sweep_checker.sv
module sweep_checker #(
    parameter int ACC_W   = 32,
    parameter int DELTA_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sweep_go,
    input logic [ACC_W-1:0] ramp_value,
    input logic             ramp_active,
    input logic             ramp_done,
    input logic [ACC_W-1:0] delta_val
);
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        ramp_done |=> !ramp_done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> !ramp_active); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ramp_active && !sweep_go) |=> $stable(ramp_value)); // R9

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (ramp_active && !sweep_go) |=>
            ((ramp_value == $past(ramp_value)) ||
             (ramp_value - $past(ramp_value) == $past(delta_val)) ||
             ($past(ramp_value) - ramp_value == $past(delta_val)))); // R4

    AST_GO_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        sweep_go |=> ramp_active); // R3
endmodule

bind lin_sweep_acc sweep_checker #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_chk (
    .clk(clk), .rst(rst), .sweep_go(sweep_go), .ramp_value(ramp_value),
    .ramp_active(ramp_active), .ramp_done(ramp_done), .delta_val(delta_val)
);

// File: tb/sim_lin_sweep_acc.sv
module sim_lin_sweep_acc;
    localparam int ACC_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [ACC_W-1:0] cfg_wdata = '0;
    logic             sweep_go = 1'b0;
    logic             sweep_down = 1'b0;
    logic [ACC_W-1:0] ramp_value;
    logic             ramp_active;
    logic             ramp_done;

    always #2 clk = ~clk;

    lin_sweep_acc u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sweep_go(sweep_go), .sweep_down(sweep_down), .ramp_value(ramp_value),
        .ramp_active(ramp_active), .ramp_done(ramp_done)
    );

    typedef struct {
        int               when;
        logic [ACC_W-1:0] val;
        logic             done;
        string            req;
    } exp_item_t;

    exp_item_t        sb[$];
    int               cyc = 0;
    int               checks = 0;
    int               errors = 0;
    logic [ACC_W-1:0] last_exp = '0;
    logic [ACC_W-1:0] prev_seen = '0;
    bit               finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item for each observed change or done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (ramp_done || ramp_value != prev_seen) begin
                if (sb.size() == 0) begin
                    check(0, "R9", "unexpected output event", longint'(ramp_value), 0);
                end else begin
                    exp_item_t it;
                    it = sb.pop_front();
                    check(cyc == it.when, it.req, "event cycle", cyc, it.when);
                    check(ramp_value == it.val, it.req, "value",
                          longint'(ramp_value), longint'(it.val));
                    check(ramp_done == it.done, it.req, "done flag",
                          longint'(ramp_done), longint'(it.done));
                    if (it.done)
                        check(ramp_active == 1'b0, "R9", "active after stop",
                              longint'(ramp_active), 0);
                end
            end
        end
        prev_seen = ramp_value;
    end

    task automatic write_reg(input int a, input longint d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = ACC_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: computes the expected event list, then runs the sweep
    task automatic run_sweep(input longint lo, input longint hi, input longint d,
                             input int k, input bit down, input int flip, input string req);
        int     keff;
        int     c0;
        longint v;
        bit     dir;
        write_reg(0, lo); write_reg(1, hi); write_reg(2, d); write_reg(3, k);
        keff = (k == 0) ? 1 : k;
        @(negedge clk);
        c0 = cyc;
        v  = down ? hi : lo;
        if (ACC_W'(v) != last_exp) sb.push_back('{c0 + 1, ACC_W'(v), 1'b0, "R3"});
        for (int n = 1; n < 1000; n++) begin
            dir = (flip >= 0 && n > flip) ? !down : down;
            if (!dir ? (v + d > hi) : (v < lo + d)) begin
                sb.push_back('{c0 + 1 + n * keff, ACC_W'(v), 1'b1, req});
                break;
            end
            v = dir ? v - d : v + d;
            sb.push_back('{c0 + 1 + n * keff, ACC_W'(v), 1'b0, req});
        end
        last_exp = ACC_W'(v);
        sweep_go = 1'b1; sweep_down = down;
        @(negedge clk);
        sweep_go = 1'b0;
        if (flip >= 0) begin
            while (cyc < c0 + 1 + flip * keff) @(negedge clk);
            sweep_down = !down;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3 * keff + 2) @(negedge clk);
        check(ramp_active == 1'b0, "R9", "idle after sweep", longint'(ramp_active), 0);
        check(ramp_value == last_exp, "R9", "value held",
              longint'(ramp_value), longint'(last_exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ramp_value == '0 && !ramp_active && !ramp_done, "R1", "reset outputs",
              longint'(ramp_value), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ramp_value == '0 && !ramp_active && !ramp_done, "R1", "after reset",
              longint'(ramp_value), 0);
        // R6 / R2 / R4: rising, exact landing on upper bound, K = 3
        run_sweep(100, 130, 10, 3, 1'b0, -1, "R6");
        // R7: falling, stops short of lower bound, K = 1
        run_sweep(5, 50, 20, 1, 1'b1, -1, "R7");
        // R5: K = 0 behaves as one step per clock
        run_sweep(0, 7, 3, 0, 1'b0, -1, "R5");
        // R8: direction flip after three steps, K = 2
        run_sweep(1000, 2000, 100, 2, 1'b0, 3, "R8");
        // R10: sum wraps past the top of the range
        run_sweep(64'hFFFF_FF00, 64'hFFFF_FFF0, 128, 1, 1'b0, -1, "R10");
        // R4: falling with wider spacing, K = 5
        run_sweep(10, 40, 7, 5, 1'b1, -1, "R4");
        check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule